// File: doc/BRIEF.md
# External Bus Release Controller

This block lets an outside bus master borrow the processor's external bus. The master pulls an active-low request line. The controller passes that line through a synchroniser and compares it with the phase of the CPU bus cycle, which a cycle-state code from the CPU bus sequencer reports. The controller never cuts an access short. It waits until the current access has finished, then pulls its active-low acknowledge low. While acknowledge is low, every bus pin driver is switched off: address, data, all chip selects, the address strobe, the read strobe and both byte-lane write strobes.

The request line is still watched on every clock while the bus is lent out. Once it is seen high, acknowledge rises and the pin drivers come back. A stall output tells the sequencer not to begin a new access. Stall rises as soon as a grant is pending. It stays high for the whole loan and for one further clock after acknowledge goes high. If the chip sleeps with every module-stop bit set, no grant is given.

Top module: `bus_release_ctrl`

## Requirements
- R1: After a synchronous reset, `bus_ack_n` is 1, every drive enable is 1 (pins driven), and `cpu_stall` is 0.
- R2: `bus_req_n` passes through a two-flop synchroniser. With the bus idle (`cyc_state` = 2'b00), a low level driven before edge 0 raises `cpu_stall` after edge 3 and pulls `bus_ack_n` low after edge 4.
- R3: During an access, the request is recognised only at the edge that ends the T1 state (`cyc_state` = 2'b01), which is the rising edge that starts T2. A request that reaches the synchroniser output after that edge is not granted within that access. It is granted from the following idle state instead.
- R4: A request recognised at T1 pulls `bus_ack_n` low at the edge that ends the access's final state (`cyc_last` = 1), never earlier. This holds for 2-state accesses (T1, T2) and for 3-state accesses (T1, T2, T3 = 2'b11).
- R5: While `bus_ack_n` is 0, `addr_oe`, `data_oe`, every bit of `cs_oe`, `as_oe`, `rd_oe`, `hwr_oe` and `lwr_oe` are all 0 (high impedance).
- R6: During the loan the synchronised request is checked on every clock. A high level driven before edge k raises `bus_ack_n` after edge k+3, and the drive enables return to 1 at the same time.
- R7: Once `bus_ack_n` falls, it stays low for at least one further clock, even if the request has already been withdrawn.
- R8: `cpu_stall` is 1 whenever `bus_ack_n` is 0. It is still 1 in the first clock after `bus_ack_n` rises, and it is 0 one clock later.
- R9: When `sleep_mode` is 1 and every bit of `stop_mask` is 1, a low request is never granted and `bus_ack_n` stays 1.
- R10: For every other combination of `sleep_mode` and `stop_mask`, an idle-bus request is granted with the timing of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_state | input | 2 | Sequencer state: 00 idle, 01 T1, 10 T2, 11 T3 |
| cyc_last | input | 1 | High in the final state of an access |
| bus_req_n | input | 1 | Asynchronous bus request, active low |
| sleep_mode | input | 1 | Chip is in sleep |
| stop_mask | input | STOP_W | Module-stop bits, 1 = module stopped |
| bus_ack_n | output | 1 | Bus acknowledge, active low |
| addr_oe | output | 1 | Address bus drive enable |
| data_oe | output | 1 | Data bus drive enable |
| cs_oe | output | NUM_CS | Chip select drive enables |
| as_oe | output | 1 | Address strobe drive enable |
| rd_oe | output | 1 | Read strobe drive enable |
| hwr_oe | output | 1 | Upper write strobe drive enable |
| lwr_oe | output | 1 | Lower write strobe drive enable |
| cpu_stall | output | 1 | Hold off new CPU accesses |

## Verification
Requests are presented in three patterns. In the first, the bus is idle, which measures the bare synchroniser-plus-decision latency. In the second, the request is timed to be valid exactly at the T1 edge of 2-state and 3-state accesses, which shows that the grant waits for the access's final state and does not simply follow the request. In the third, the request arrives just after T1, which separates sampling at T1 from sampling at every state. All sixteen combinations of sleep and a 3-bit stop mask are swept, so the single inhibiting combination stands apart from its neighbours. An early withdrawal confirms the one-state minimum loan.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'b00,
    CYC_T1   = 2'b01,
    CYC_T2   = 2'b10,
    CYC_T3   = 2'b11
  } cyc_e;

  typedef enum logic [1:0] {
    ST_OWN    = 2'b00,
    ST_PEND   = 2'b01,
    ST_REL    = 2'b10,
    ST_RESUME = 2'b11
  } rel_st_e;
endpackage

// File: rtl/brc_sync.sv
module brc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/brc_fsm.sv
module brc_fsm
  import brc_pkg::*;
#(
  parameter int STOP_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cyc_state,
  input  logic              cyc_last,
  input  logic              req_sync_n,
  input  logic              sleep_mode,
  input  logic [STOP_W-1:0] stop_mask,
  output logic              rel_nxt,
  output logic              stall_nxt
);
  rel_st_e st_q, st_d;
  cyc_e    cyc;
  logic    inhibit;
  logic    req_on;
  logic    boundary;

  assign cyc      = cyc_e'(cyc_state);
  assign inhibit  = sleep_mode && (&stop_mask);
  assign req_on   = !req_sync_n && !inhibit;
  // Either the bus is idle or this is the last state of an access.
  assign boundary = (cyc == CYC_IDLE) || cyc_last;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OWN: begin
        if (req_on && (cyc == CYC_IDLE || cyc == CYC_T1)) st_d = ST_PEND;
      end
      ST_PEND: begin
        if (boundary) st_d = req_on ? ST_REL : ST_OWN;
      end
      ST_REL: begin
        if (req_sync_n) st_d = ST_RESUME;
      end
      ST_RESUME: st_d = ST_OWN;
      default:   st_d = ST_OWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_OWN;
    else     st_q <= st_d;
  end

  assign rel_nxt   = (st_d == ST_REL);
  assign stall_nxt = (st_d != ST_OWN);
endmodule

// File: rtl/brc_pin_ctrl.sv
module brc_pin_ctrl #(
  parameter int NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rel_nxt,
  input  logic              stall_nxt,
  output logic              bus_ack_n,
  output logic              addr_oe,
  output logic              data_oe,
  output logic [NUM_CS-1:0] cs_oe,
  output logic              as_oe,
  output logic              rd_oe,
  output logic              hwr_oe,
  output logic              lwr_oe,
  output logic              cpu_stall
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack_n <= 1'b1;
      addr_oe   <= 1'b1;
      data_oe   <= 1'b1;
      as_oe     <= 1'b1;
      rd_oe     <= 1'b1;
      hwr_oe    <= 1'b1;
      lwr_oe    <= 1'b1;
      cpu_stall <= 1'b0;
    end else begin
      bus_ack_n <= !rel_nxt;
      addr_oe   <= !rel_nxt;
      data_oe   <= !rel_nxt;
      as_oe     <= !rel_nxt;
      rd_oe     <= !rel_nxt;
      hwr_oe    <= !rel_nxt;
      lwr_oe    <= !rel_nxt;
      cpu_stall <= stall_nxt;
    end
  end

  // One enable flop per chip select.
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) cs_oe[i] <= 1'b1;
      else     cs_oe[i] <= !rel_nxt;
    end
  end
endmodule

// File: rtl/bus_release_ctrl.sv
module bus_release_ctrl #(
  parameter int NUM_CS      = 8,
  parameter int STOP_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cyc_state,
  input  logic              cyc_last,
  input  logic              bus_req_n,
  input  logic              sleep_mode,
  input  logic [STOP_W-1:0] stop_mask,
  output logic              bus_ack_n,
  output logic              addr_oe,
  output logic              data_oe,
  output logic [NUM_CS-1:0] cs_oe,
  output logic              as_oe,
  output logic              rd_oe,
  output logic              hwr_oe,
  output logic              lwr_oe,
  output logic              cpu_stall
);
  logic req_sync_n;
  logic rel_nxt;
  logic stall_nxt;

  brc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (bus_req_n),
    .dout(req_sync_n)
  );

  brc_fsm #(.STOP_W(STOP_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cyc_state (cyc_state),
    .cyc_last  (cyc_last),
    .req_sync_n(req_sync_n),
    .sleep_mode(sleep_mode),
    .stop_mask (stop_mask),
    .rel_nxt   (rel_nxt),
    .stall_nxt (stall_nxt)
  );

  brc_pin_ctrl #(.NUM_CS(NUM_CS)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .rel_nxt  (rel_nxt),
    .stall_nxt(stall_nxt),
    .bus_ack_n(bus_ack_n),
    .addr_oe  (addr_oe),
    .data_oe  (data_oe),
    .cs_oe    (cs_oe),
    .as_oe    (as_oe),
    .rd_oe    (rd_oe),
    .hwr_oe   (hwr_oe),
    .lwr_oe   (lwr_oe),
    .cpu_stall(cpu_stall)
  );
endmodule

// File: rtl/brc_chk.sv
module brc_chk #(
  parameter int NUM_CS = 8,
  parameter int STOP_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cyc_state,
  input logic              cyc_last,
  input logic              sleep_mode,
  input logic [STOP_W-1:0] stop_mask,
  input logic              bus_ack_n,
  input logic              addr_oe,
  input logic              data_oe,
  input logic [NUM_CS-1:0] cs_oe,
  input logic              as_oe,
  input logic              rd_oe,
  input logic              hwr_oe,
  input logic              lwr_oe,
  input logic              cpu_stall
);
  // R4
  grant_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ack_n) |-> ($past(cyc_state) == 2'b00 || $past(cyc_last)));

  // R5
  pins_floated_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_ack_n |-> (!addr_oe && !data_oe && cs_oe == '0 && !as_oe && !rd_oe && !hwr_oe && !lwr_oe));

  // R7
  min_loan_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ack_n) |=> !bus_ack_n);

  // R8
  stall_in_loan_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_ack_n |-> cpu_stall);

  // R8
  stall_tail_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ack_n) |-> cpu_stall);

  // R9
  sleep_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ack_n) |-> !($past(sleep_mode) && (&$past(stop_mask))));
endmodule

bind bus_release_ctrl brc_chk #(.NUM_CS(NUM_CS), .STOP_W(STOP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc_state (cyc_state),
  .cyc_last  (cyc_last),
  .sleep_mode(sleep_mode),
  .stop_mask (stop_mask),
  .bus_ack_n (bus_ack_n),
  .addr_oe   (addr_oe),
  .data_oe   (data_oe),
  .cs_oe     (cs_oe),
  .as_oe     (as_oe),
  .rd_oe     (rd_oe),
  .hwr_oe    (hwr_oe),
  .lwr_oe    (lwr_oe),
  .cpu_stall (cpu_stall)
);

// File: tb/bus_release_ctrl_tb_top.sv
module bus_release_ctrl_tb_top;
  localparam int NUM_CS = 8;
  localparam int STOP_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        cyc_state = 2'b00;
  logic              cyc_last = 1'b0;
  logic              bus_req_n = 1'b1;
  logic              sleep_mode = 1'b0;
  logic [STOP_W-1:0] stop_mask = '0;
  logic              bus_ack_n, addr_oe, data_oe, as_oe, rd_oe, hwr_oe, lwr_oe, cpu_stall;
  logic [NUM_CS-1:0] cs_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bus_release_ctrl #(.NUM_CS(NUM_CS), .STOP_W(STOP_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .cyc_state(cyc_state), .cyc_last(cyc_last),
    .bus_req_n(bus_req_n), .sleep_mode(sleep_mode), .stop_mask(stop_mask),
    .bus_ack_n(bus_ack_n), .addr_oe(addr_oe), .data_oe(data_oe), .cs_oe(cs_oe),
    .as_oe(as_oe), .rd_oe(rd_oe), .hwr_oe(hwr_oe), .lwr_oe(lwr_oe),
    .cpu_stall(cpu_stall)
  );

  function automatic int pins();
    return {addr_oe, data_oe, as_oe, rd_oe, hwr_oe, lwr_oe, cs_oe};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic access(input int nstates);
    cyc_state = 2'b01; cyc_last = 1'b0; tick(1);
    cyc_state = 2'b10; cyc_last = (nstates == 2); tick(1);
    if (nstates == 3) begin
      cyc_state = 2'b11; cyc_last = 1'b1; tick(1);
    end
    cyc_state = 2'b00; cyc_last = 1'b0;
  endtask

  task automatic give_back();
    bus_req_n = 1'b1;
    tick(3);
    chk("R6 ack high 3 edges after withdraw", bus_ack_n, 1);
    chk("R6 pins driven again", pins(), 'h3FFF);
    chk("R8 stall tail clock", cpu_stall, 1);
    tick(1);
    chk("R8 stall low after tail", cpu_stall, 0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    chk("R1 ack reset", bus_ack_n, 1);
    chk("R1 pins reset", pins(), 'h3FFF);
    chk("R1 stall reset", cpu_stall, 0);

    // Idle-bus grant
    bus_req_n = 1'b0;
    tick(3);
    chk("R2 stall at edge 3", cpu_stall, 1);
    chk("R2 ack still high at edge 3", bus_ack_n, 1);
    tick(1);
    chk("R2 ack low at edge 4", bus_ack_n, 0);
    chk("R5 all pins floated", pins(), 0);
    chk("R8 stall during loan", cpu_stall, 1);
    tick(5);
    chk("R6 loan held while request low", bus_ack_n, 0);
    give_back();

    // Request valid exactly at the T1 edge, 2-state and 3-state accesses
    for (int n = 2; n <= 3; n++) begin
      tick(2);
      bus_req_n = 1'b0;
      tick(2);
      cyc_state = 2'b01; cyc_last = 1'b0; tick(1);
      chk("R3 recognised at T1 edge (stall)", cpu_stall, 1);
      chk("R4 no ack inside access", bus_ack_n, 1);
      cyc_state = 2'b10; cyc_last = (n == 2); tick(1);
      if (n == 3) begin
        chk("R4 no ack before final state", bus_ack_n, 1);
        cyc_state = 2'b11; cyc_last = 1'b1; tick(1);
      end
      cyc_state = 2'b00; cyc_last = 1'b0;
      chk("R4 ack low after final state", bus_ack_n, 0);
      give_back();
    end

    // Request arriving just after T1 is not honoured in that access
    tick(2);
    bus_req_n = 1'b0;
    access(3);
    chk("R3 missed T1: no stall at access end", cpu_stall, 0);
    chk("R3 missed T1: no ack at access end", bus_ack_n, 1);
    tick(1);
    chk("R3 idle pickup: stall", cpu_stall, 1);
    chk("R3 idle pickup: ack still high", bus_ack_n, 1);
    tick(1);
    chk("R3 idle pickup: ack low", bus_ack_n, 0);
    give_back();

    // Early withdrawal: one-state minimum
    tick(2);
    bus_req_n = 1'b0;
    tick(3);
    bus_req_n = 1'b1;
    tick(1);
    chk("R7 ack low despite withdrawal", bus_ack_n, 0);
    tick(1);
    chk("R7 ack held a further clock", bus_ack_n, 0);
    tick(1);
    chk("R7 ack high after loan", bus_ack_n, 1);
    tick(2);

    // Sleep / stop-mask sweep
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < (1 << STOP_W); m++) begin
        sleep_mode = s[0];
        stop_mask  = m[STOP_W-1:0];
        bus_req_n  = 1'b0;
        tick(6);
        if (s == 1 && m == (1 << STOP_W) - 1)
          chk("R9 inhibited in sleep with full stop mask", bus_ack_n, 1);
        else
          chk("R10 granted for this sleep/mask", bus_ack_n, 0);
        bus_req_n = 1'b1;
        tick(6);
        chk("R6 returned after sweep point", bus_ack_n, 1);
      end
    end
    sleep_mode = 1'b0;
    stop_mask  = '0;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule